// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the host side of an asynchronous NOR flash bus. A client hands it one request at a time: program one word, erase one sector, erase the whole array, or pulse the flash reset line. The block then drives the unlock and command write cycles on the flash bus. Every strobe width comes from a cycle-count parameter, so the same logic fits any system clock once the nanosecond limits are rounded up to cycles.

After the last command write, the sequencer reads the target location over and over. Each read compares data bit 7 against the value the finished operation will show. That value is the programmed word's bit 7 for a program and 1 for either erase, because erased cells read as all ones. On a match it raises `done` for one cycle. If polling runs past the limit set for that operation, it raises `error` instead.

The data bus is split into an output word, an output-enable and an input word, so that a pad ring can build the tri-state buffer.

Top module: `nor_prog_seq`

## Requirements
- R1: A request with op code 0 (program) issues exactly four write cycles in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R2: A request with op code 1 (sector erase) issues exactly six write cycles: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at the request address.
- R3: A request with op code 2 (chip erase) issues the same first five write cycles as a sector erase, and its sixth write is 10h at 5555h.
- R4: Each write enable low pulse lasts at least WE_LOW_CYC cycles. Between two writes of one operation, write enable stays high at least WE_HIGH_CYC cycles. Address and output data hold steady for the whole low pulse.
- R5: The data output enable is high exactly while write enable is low. Output enable and write enable are never low together, and the data bus is released whenever output enable is low.
- R6: After the last write, the block makes polling reads, each holding output enable low for RD_CYC cycles and then high for GAP_CYC+1 cycles. `done` rises exactly 1 + N*(WE_LOW_CYC+WE_HIGH_CYC) + (P+1)*(RD_CYC+GAP_CYC+1) cycles after the accepting cycle. Here N is the write count and P is the number of reads whose bit 7 differed from the expected value (program: data bit 7; erase: 1).
- R7: If no read matches, `error` rises instead of `done`. This happens once the time spent polling has reached the operation's limit (PROG_TO_CYC, SECT_TO_CYC or CHIP_TO_CYC), and no later than two read periods beyond that limit.
- R8: A request with op code 3 (reset) drives the flash reset line low for exactly RST_LOW_CYC cycles and issues no write or read. It raises `done` RST_WAIT_CYC cycles after the reset line returns high.
- R9: A request is taken only in a cycle where `busy` is low. `busy` is high from the next cycle until the cycle in which `done` or `error` shows. `done` and `error` are single-cycle pulses that never coincide. A request made while busy has no effect.
- R10: While the block is held in reset, `busy`, `done`, `error` and the data output enable are low, and chip select, output enable, write enable and flash reset are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 flash reset |
| reqAddr | input | ADDR_W | Target word or sector address |
| reqData | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on success |
| error | output | 1 | One-cycle pulse on polling timeout |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDqOut | output | DATA_W | Data driven toward the flash |
| flashDqOe | output | 1 | Data output enable (1 drives the bus) |
| flashDqIn | input | DATA_W | Data read from the flash |
| flashCeN | output | 1 | Chip select, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, active low |
| flashRstN | output | 1 | Flash reset, active low |

## Verification
The assertions assume a well-formed client. They expect `reqOp` to be stable in the accepting cycle. They also expect the flash read data to be settled by the edge that closes each polling read.

The bench's flash model meets both assumptions. It changes its bit 7 answer only on the rising edge of output enable, after the read has been sampled. Requests are driven on falling clock edges and held for a whole cycle.

The one request made while the block is busy is kept to a single cycle in the middle of an operation. The block's behaviour for it is therefore observed directly at the bus, not assumed.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RST  = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    AS_UNLK1 = 2'd0,
    AS_UNLK2 = 2'd1,
    AS_REQ   = 2'd2
  } addrSel_e;

  typedef enum logic [2:0] {
    DS_AA  = 3'd0,
    DS_55  = 3'd1,
    DS_A0  = 3'd2,
    DS_80  = 3'd3,
    DS_30  = 3'd4,
    DS_10  = 3'd5,
    DS_REQ = 3'd6
  } dataSel_e;

  // strobes from control to datapath, one cycle ahead of the pins
  typedef struct packed {
    logic     capture;
    logic     ceOn;
    logic     weOn;
    logic     oeOn;
    logic     rstOn;
    logic     sample;
    logic     polling;
    addrSel_e addrSel;
    dataSel_e dataSel;
  } busStrobe_t;

  localparam logic [14:0] UNLK1_ADDR = 15'h5555;
  localparam logic [14:0] UNLK2_ADDR = 15'h2AAA;
  localparam logic [2:0]  PROG_LAST  = 3'd3;
  localparam logic [2:0]  ERASE_LAST = 3'd5;

  function automatic int unsigned maxU(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic longint unsigned maxL(longint unsigned a, longint unsigned b);
    return (a > b) ? a : b;
  endfunction

  // address used by write step 'step' of operation 'op'
  function automatic addrSel_e stepAddr(opKind_e op, logic [2:0] step);
    if (op == OP_PROG && step == 3'd3) return AS_REQ;
    if (step == 3'd5) return (op == OP_CHIP) ? AS_UNLK1 : AS_REQ;
    if (step == 3'd1 || step == 3'd4) return AS_UNLK2;
    return AS_UNLK1;
  endfunction

  // data used by write step 'step' of operation 'op'
  function automatic dataSel_e stepData(opKind_e op, logic [2:0] step);
    case (step)
      3'd0:    return DS_AA;
      3'd1:    return DS_55;
      3'd2:    return (op == OP_PROG) ? DS_A0 : DS_80;
      3'd3:    return (op == OP_PROG) ? DS_REQ : DS_AA;
      3'd4:    return DS_55;
      default: return (op == OP_CHIP) ? DS_10 : DS_30;
    endcase
  endfunction

endpackage

// File: rtl/nor_prog_dp.sv
module nor_prog_dp
  import nor_prog_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 21,
  parameter int unsigned     DATA_W      = 16,
  parameter int unsigned     WE_LOW_CYC  = 6,
  parameter int unsigned     WE_HIGH_CYC = 6,
  parameter int unsigned     RST_LOW_CYC = 63,
  parameter longint unsigned PROG_TO_CYC = 64'd37500,
  parameter longint unsigned SECT_TO_CYC = 64'd1875000000,
  parameter longint unsigned CHIP_TO_CYC = 64'd32000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  opKind_e           reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] flashDqIn,
  output logic              pollHit,
  output logic              toExpired,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDqOut,
  output logic              flashDqOe,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic              flashRstN
);

  localparam longint unsigned TO_MAX = maxL(maxL(PROG_TO_CYC, SECT_TO_CYC), CHIP_TO_CYC);
  localparam int TO_W  = $clog2(TO_MAX + 1) + 1;
  localparam int WLO_W = $clog2(WE_LOW_CYC + 2);
  localparam int WHI_W = $clog2(WE_HIGH_CYC + 2);
  localparam int RST_W = $clog2(RST_LOW_CYC + 2);

  opKind_e           opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] dataNext;
  logic              sampledBit;
  logic              expectBit;
  logic [TO_W-1:0]   toCnt;
  logic [TO_W-1:0]   toLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_PROG;
      addrQ <= '0;
      dataQ <= '0;
    end else if (stb.capture) begin
      opQ   <= reqOp;
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  always_comb begin
    case (stb.addrSel)
      AS_UNLK1: addrNext = ADDR_W'(UNLK1_ADDR);
      AS_UNLK2: addrNext = ADDR_W'(UNLK2_ADDR);
      default:  addrNext = addrQ;
    endcase
    case (stb.dataSel)
      DS_AA:   dataNext = DATA_W'(8'hAA);
      DS_55:   dataNext = DATA_W'(8'h55);
      DS_A0:   dataNext = DATA_W'(8'hA0);
      DS_80:   dataNext = DATA_W'(8'h80);
      DS_30:   dataNext = DATA_W'(8'h30);
      DS_10:   dataNext = DATA_W'(8'h10);
      default: dataNext = dataQ;
    endcase
  end

  // registered bus pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCeN   <= 1'b1;
      flashOeN   <= 1'b1;
      flashWeN   <= 1'b1;
      flashRstN  <= 1'b1;
      flashDqOe  <= 1'b0;
      flashAddr  <= '0;
      flashDqOut <= '0;
    end else begin
      flashCeN   <= !stb.ceOn;
      flashOeN   <= !stb.oeOn;
      flashWeN   <= !stb.weOn;
      flashRstN  <= !stb.rstOn;
      flashDqOe  <= stb.weOn;
      flashAddr  <= addrNext;
      flashDqOut <= dataNext;
    end
  end

  // polling compare and timeout
  assign expectBit = (opQ == OP_PROG) ? dataQ[7] : 1'b1;
  assign pollHit   = (sampledBit == expectBit);

  always_comb begin
    case (opQ)
      OP_PROG: toLimit = TO_W'(PROG_TO_CYC);
      OP_SECT: toLimit = TO_W'(SECT_TO_CYC);
      default: toLimit = TO_W'(CHIP_TO_CYC);
    endcase
  end
  assign toExpired = (toCnt >= toLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampledBit <= 1'b0;
      toCnt      <= '0;
    end else begin
      if (stb.sample) sampledBit <= flashDqIn[7];
      if (!stb.polling)   toCnt <= '0;
      else if (!toExpired) toCnt <= toCnt + 1'b1;
    end
  end

  // pulse-width monitors for the checks below
  logic [WLO_W-1:0] weLowRun;
  logic [WHI_W-1:0] weHighRun;
  logic [RST_W-1:0] rstRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun  <= '0;
      weHighRun <= '1;
      rstRun    <= '0;
    end else begin
      if (!flashWeN) weLowRun <= (weLowRun == '1) ? weLowRun : weLowRun + 1'b1;
      else           weLowRun <= '0;
      if (flashWeN && !flashCeN) weHighRun <= (weHighRun == '1) ? weHighRun : weHighRun + 1'b1;
      else if (flashCeN)         weHighRun <= '1;
      else                       weHighRun <= '0;
      if (!flashRstN) rstRun <= (rstRun == '1) ? rstRun : rstRun + 1'b1;
      else            rstRun <= '0;
    end
  end

  // R5
  no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashOeN && !flashWeN));

  // R5
  read_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> !flashDqOe);

  // R4
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> (weLowRun >= WLO_W'(WE_LOW_CYC)));

  // R4
  we_high_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWeN) |-> (weHighRun >= WHI_W'(WE_HIGH_CYC)));

  // R4
  write_bus_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashDqOut)));

  // R8
  rst_low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashRstN) |-> (rstRun >= RST_W'(RST_LOW_CYC)));

endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
  import nor_prog_pkg::*;
#(
  parameter int unsigned WE_LOW_CYC   = 6,
  parameter int unsigned WE_HIGH_CYC  = 6,
  parameter int unsigned RD_CYC       = 12,
  parameter int unsigned GAP_CYC      = 2,
  parameter int unsigned RST_LOW_CYC  = 63,
  parameter int unsigned RST_WAIT_CYC = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  opKind_e    reqOp,
  input  logic       pollHit,
  input  logic       toExpired,
  output busStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       error
);

  localparam int unsigned PH_MAX = maxU(maxU(maxU(WE_LOW_CYC, WE_HIGH_CYC), maxU(RD_CYC, GAP_CYC)),
                                        maxU(RST_LOW_CYC, RST_WAIT_CYC));
  localparam int PH_W = $clog2(PH_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WR_LO, S_WR_HI, S_RD, S_GAP, S_EVAL, S_RST_LO, S_RST_WAIT
  } state_e;

  state_e          state;
  opKind_e         opQ;
  logic [2:0]      stepQ;
  logic [PH_W-1:0] phCnt;
  logic            phDone;
  logic [2:0]      lastStep;

  assign phDone   = (phCnt == '0);
  assign lastStep = (opQ == OP_PROG) ? PROG_LAST : ERASE_LAST;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_PROG;
      stepQ <= '0;
      phCnt <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (!phDone) phCnt <= phCnt - 1'b1;
      case (state)
        S_IDLE: if (reqValid) begin
          opQ   <= reqOp;
          stepQ <= '0;
          if (reqOp == OP_RST) begin
            state <= S_RST_LO;
            phCnt <= PH_W'(RST_LOW_CYC - 1);
          end else begin
            state <= S_WR_LO;
            phCnt <= PH_W'(WE_LOW_CYC - 1);
          end
        end
        S_WR_LO: if (phDone) begin
          state <= S_WR_HI;
          phCnt <= PH_W'(WE_HIGH_CYC - 1);
        end
        S_WR_HI: if (phDone) begin
          if (stepQ == lastStep) begin
            state <= S_RD;
            phCnt <= PH_W'(RD_CYC - 1);
          end else begin
            stepQ <= stepQ + 1'b1;
            state <= S_WR_LO;
            phCnt <= PH_W'(WE_LOW_CYC - 1);
          end
        end
        S_RD: if (phDone) begin
          state <= S_GAP;
          phCnt <= PH_W'(GAP_CYC - 1);
        end
        S_GAP: if (phDone) state <= S_EVAL;
        S_EVAL: begin
          if (pollHit) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (toExpired) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_RD;
            phCnt <= PH_W'(RD_CYC - 1);
          end
        end
        S_RST_LO: if (phDone) begin
          state <= S_RST_WAIT;
          phCnt <= PH_W'(RST_WAIT_CYC - 1);
        end
        default: if (phDone) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    stb.capture = (state == S_IDLE) && reqValid;
    stb.ceOn    = (state == S_WR_LO) || (state == S_WR_HI) || (state == S_RD);
    stb.weOn    = (state == S_WR_LO);
    stb.oeOn    = (state == S_RD);
    stb.rstOn   = (state == S_RST_LO);
    stb.sample  = (state == S_GAP) && (phCnt == PH_W'(GAP_CYC - 1));
    stb.polling = (state == S_RD) || (state == S_GAP) || (state == S_EVAL);
    stb.addrSel = stb.polling ? AS_REQ : stepAddr(opQ, stepQ);
    stb.dataSel = stepData(opQ, stepQ);
  end

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R9
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |=> !(done || error));

  // R9
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R6
  hit_gives_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVAL && pollHit) |=> done);

  // R7
  error_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> $past(toExpired && !pollHit));

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nor_prog_pkg::*;
#(
  parameter int unsigned     ADDR_W       = 21,
  parameter int unsigned     DATA_W       = 16,
  parameter int unsigned     WE_LOW_CYC   = 6,
  parameter int unsigned     WE_HIGH_CYC  = 6,
  parameter int unsigned     RD_CYC       = 12,
  parameter int unsigned     GAP_CYC      = 2,
  parameter int unsigned     RST_LOW_CYC  = 63,
  parameter int unsigned     RST_WAIT_CYC = 2500,
  parameter longint unsigned PROG_TO_CYC  = 64'd37500,
  parameter longint unsigned SECT_TO_CYC  = 64'd1875000000,
  parameter longint unsigned CHIP_TO_CYC  = 64'd32000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDqOut,
  output logic              flashDqOe,
  input  logic [DATA_W-1:0] flashDqIn,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic              flashRstN
);

  busStrobe_t stb;
  logic       pollHit;
  logic       toExpired;
  opKind_e    opIn;

  assign opIn = opKind_e'(reqOp);

  nor_prog_ctrl #(
    .WE_LOW_CYC  (WE_LOW_CYC),
    .WE_HIGH_CYC (WE_HIGH_CYC),
    .RD_CYC      (RD_CYC),
    .GAP_CYC     (GAP_CYC),
    .RST_LOW_CYC (RST_LOW_CYC),
    .RST_WAIT_CYC(RST_WAIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (opIn),
    .pollHit  (pollHit),
    .toExpired(toExpired),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  nor_prog_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WE_LOW_CYC (WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC),
    .RST_LOW_CYC(RST_LOW_CYC),
    .PROG_TO_CYC(PROG_TO_CYC),
    .SECT_TO_CYC(SECT_TO_CYC),
    .CHIP_TO_CYC(CHIP_TO_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqOp     (opIn),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .flashDqIn (flashDqIn),
    .pollHit   (pollHit),
    .toExpired (toExpired),
    .flashAddr (flashAddr),
    .flashDqOut(flashDqOut),
    .flashDqOe (flashDqOe),
    .flashCeN  (flashCeN),
    .flashOeN  (flashOeN),
    .flashWeN  (flashWeN),
    .flashRstN (flashRstN)
  );

endmodule

// File: tb/tb_nor_prog_seq.sv
module tb_nor_prog_seq;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int WL = 2;
  localparam int WH = 3;
  localparam int RD = 3;
  localparam int GP = 1;
  localparam int RL = 4;
  localparam int RW = 9;
  localparam int TO_P = 40;
  localparam int TO_S = 70;
  localparam int TO_C = 100;
  localparam int RDP = RD + GP + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          busy, done, error;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] flashDqOut;
  logic          flashDqOe;
  logic [DW-1:0] flashDqIn;
  logic          flashCeN, flashOeN, flashWeN, flashRstN;

  nor_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH),
    .RD_CYC(RD), .GAP_CYC(GP), .RST_LOW_CYC(RL), .RST_WAIT_CYC(RW),
    .PROG_TO_CYC(TO_P), .SECT_TO_CYC(TO_S), .CHIP_TO_CYC(TO_C)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .error(error), .flashAddr(flashAddr), .flashDqOut(flashDqOut),
    .flashDqOe(flashDqOe), .flashDqIn(flashDqIn), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN), .flashRstN(flashRstN)
  );

  int total = 0;
  int bad = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // flash model
  int            pollsLeft = 0;
  bit            expBit = 1'b1;
  logic [DW-1:0] curData = '0;
  assign flashDqIn = {curData[15:8], expBit ^ (pollsLeft > 0), ~curData[6:0]};

  always @(posedge flashOeN) if (rstN && pollsLeft > 0) pollsLeft--;

  int            logN = 0;
  logic [AW-1:0] logA [8];
  logic [DW-1:0] logD [8];
  always @(posedge flashWeN) if (rstN) begin
    if (logN < 8) begin
      logA[logN] = flashAddr;
      logD[logN] = flashDqOut;
    end
    logN++;
  end

  // bus monitor
  int overlapV = 0, driveV = 0, stableV = 0, rstV = 0;
  int lowRun = 0, highRun = 0, minLow = 1000, minHigh = 1000;
  int rstRun = 0, lastRstLow = 0, sinceRst = 100000;
  bit prevLow = 1'b0;
  logic [AW-1:0] prevA;
  logic [DW-1:0] prevD;

  always @(negedge clk) if (rstN) begin
    if (!flashOeN && !flashWeN) overlapV++;
    if (flashDqOe && flashWeN) driveV++;
    if (!flashWeN && !flashDqOe) driveV++;
    if (!flashOeN && flashDqOe) driveV++;
    if (!flashWeN && prevLow && (flashAddr != prevA || flashDqOut != prevD)) stableV++;
    if (!flashWeN) begin
      if (!prevLow && highRun > 0 && highRun < minHigh) minHigh = highRun;
      lowRun++;
      highRun = 0;
    end else begin
      if (prevLow && lowRun < minLow) minLow = lowRun;
      lowRun = 0;
      if (!flashCeN) highRun++;
      else highRun = 0;
    end
    prevLow = !flashWeN;
    prevA = flashAddr;
    prevD = flashDqOut;
    if (!flashRstN) begin
      rstRun++;
      sinceRst = 0;
    end else begin
      if (rstRun > 0) lastRstLow = rstRun;
      rstRun = 0;
      if ((!flashOeN || !flashWeN) && sinceRst < RW) rstV++;
      sinceRst++;
    end
  end

  function automatic logic [AW-1:0] expA(int op, int i, logic [AW-1:0] a);
    if (op == 0) return (i == 3) ? a : ((i == 1) ? 21'h2AAA : 21'h5555);
    if (i == 5) return (op == 2) ? 21'h5555 : a;
    return (i == 1 || i == 4) ? 21'h2AAA : 21'h5555;
  endfunction

  function automatic logic [DW-1:0] expD(int op, int i, logic [DW-1:0] d);
    case (i)
      0: return 16'h00AA;
      1: return 16'h0055;
      2: return (op == 0) ? 16'h00A0 : 16'h0080;
      3: return (op == 0) ? d : 16'h00AA;
      4: return 16'h0055;
      default: return (op == 2) ? 16'h0010 : 16'h0030;
    endcase
  endfunction

  int  lat;
  bit  gotErr, gotDone, busyStart;

  task automatic runOp(int op, logic [AW-1:0] a, logic [DW-1:0] d, int polls, int injectAt);
    @(negedge clk);
    pollsLeft = polls;
    curData = d;
    expBit = (op == 0) ? d[7] : 1'b1;
    logN = 0;
    reqOp = 2'(op);
    reqAddr = a;
    reqData = d;
    reqValid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        reqValid = 1'b0;
        busyStart = busy;
      end
      if (injectAt > 0 && lat == injectAt) begin
        reqValid = 1'b1;
        reqOp = 2'd2;
        reqAddr = '1;
      end else if (injectAt > 0 && lat == injectAt + 1) begin
        reqValid = 1'b0;
      end
    end while (!(done || error) && lat < 3000);
    gotErr = error;
    gotDone = done;
    check(lat < 3000, "R9", "operation hung, cycles", lat, 0);
  endtask

  task automatic seqOp(int op, logic [AW-1:0] a, logic [DW-1:0] d, int polls);
    int n;
    int mism;
    string tag;
    n = (op == 0) ? 4 : 6;
    tag = (op == 0) ? "R1" : ((op == 1) ? "R2" : "R3");
    runOp(op, a, d, polls, 0);
    check(busyStart, "R9", "busy after accept", busyStart, 1);
    check(gotDone && !gotErr && !busy, "R9", "done pulse without error", {gotDone, gotErr}, 2);
    check(lat == n * (WL + WH) + (polls + 1) * RDP + 1, "R6", "done latency", lat,
          n * (WL + WH) + (polls + 1) * RDP + 1);
    check(logN == n, tag, "write count", logN, n);
    mism = 0;
    for (int i = 0; i < n && i < 8; i++)
      if (logA[i] !== expA(op, i, a) || logD[i] !== expD(op, i, d)) mism++;
    check(mism == 0, tag, "mismatching write cycles", mism, 0);
  endtask

  task automatic timeoutOp(int op, int limit);
    int n;
    int pollTime;
    n = (op == 0) ? 4 : 6;
    runOp(op, 21'h0A_5000, 16'h0080, 100000, 0);
    pollTime = lat - 1 - n * (WL + WH);
    check(gotErr && !gotDone, "R7", "error instead of done", {gotErr, gotDone}, 2);
    check(pollTime >= limit && pollTime <= limit + 2 * RDP, "R7", "polling time before error",
          pollTime, limit);
  endtask

  initial begin
    logic [DW-1:0] pats [5];
    pats[0] = 16'h0000; pats[1] = 16'h0080; pats[2] = 16'h1234;
    pats[3] = 16'hFFFF; pats[4] = 16'hAB7F;

    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !error, "R10", "handshake in reset", {busy, done, error}, 0);
    check(flashCeN && flashOeN && flashWeN && flashRstN && !flashDqOe, "R10", "bus idle in reset",
          {flashCeN, flashOeN, flashWeN, flashRstN, flashDqOe}, 5'b11110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // program sweep: data patterns x mismatching reads (R1, R6)
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 4; p++)
        seqOp(0, AW'(21'h01_0000 * k + p * 3 + 1), pats[k], p);

    // sector erase over every 64K-word sector (R2, R6)
    for (int s = 0; s < 32; s++)
      seqOp(1, AW'(s) << 16, 16'h0000, s % 5);

    // chip erase (R3, R6)
    for (int p = 0; p < 4; p++)
      seqOp(2, AW'(21'h1F_0000 + p), 16'h0000, p);

    // flash reset request (R8)
    runOp(3, '0, '0, 0, 0);
    check(gotDone && !gotErr, "R8", "reset request ends with done", {gotDone, gotErr}, 2);
    check(lat == RL + RW + 1, "R8", "reset request latency", lat, RL + RW + 1);
    check(lastRstLow == RL, "R8", "reset low width", lastRstLow, RL);
    check(logN == 0, "R8", "writes during reset request", logN, 0);

    // reset request followed directly by a program
    seqOp(0, 21'h00_0042, 16'h5A5A, 1);
    check(rstV == 0, "R8", "bus cycles within wait after reset", rstV, 0);

    // timeouts (R7)
    timeoutOp(0, TO_P);
    timeoutOp(1, TO_S);
    timeoutOp(2, TO_C);

    // request while busy is ignored (R9)
    runOp(0, 21'h00_1234, 16'h0055, 2, 6);
    check(gotDone && lat == 4 * (WL + WH) + 3 * RDP + 1, "R9", "latency with request while busy",
          lat, 4 * (WL + WH) + 3 * RDP + 1);
    repeat (10) @(negedge clk);
    check(!busy && logN == 4, "R9", "writes after ignored request", logN, 4);

    // bus rules over the whole run
    check(overlapV == 0, "R5", "OE and WE low together", overlapV, 0);
    check(driveV == 0, "R5", "data drive outside write low", driveV, 0);
    check(stableV == 0, "R4", "bus change during WE low", stableV, 0);
    check(minLow >= WL, "R4", "shortest WE low", minLow, WL);
    check(minHigh >= WH, "R4", "shortest WE high between writes", minHigh, WH);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL R9 watchdog expired: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule